// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Sequencer

This block sits on the host side of a byte-wide parallel EEPROM and carries out one page write at a time. A request names the 9-bit page and the number of bytes to load (1 to 64). The bytes then arrive as (offset, data) pairs over a valid/ready handshake, in any offset order. For each byte the sequencer drives chip-enable, write-enable and output-enable, a 15-bit address and an 8-bit data bus. It keeps setup and hold margins around every write strobe and a fixed strobe width. The gap between strobes stays inside the device's load window.

After the last strobe, write-enable stays high long enough for the device to start programming. Chip-enable is then released and the sequencer waits out the write-cycle time before it pulses done. If the byte stream stalls so long that the load window would close, the sequencer stops early and raises an underrun flag. The device then programs only what was loaded, and the sequence finishes as usual. All timing values are cycle-count parameters.

Top module: `pgwr_seq`

## Requirements
- R1: After reset, and between sequences, mem_ce_n, mem_we_n and mem_oe_n are high, req_ready is high, byte_ready is low, and seq_done and seq_underrun are low.
- R2: A request with req_len_m1 = n gives exactly n+1 write strobes. Each strobe writes the data of one accepted byte at address {page, offset}, where mem_addr[14:6] is the page and mem_addr[5:0] is the offset. Offsets may arrive in any order.
- R3: While mem_ce_n is low, mem_addr[14:6] holds the requested page without change. mem_oe_n is never low.
- R4: Every low pulse of mem_we_n lasts exactly PULSE_CYC cycles.
- R5: mem_addr and mem_dq are stable for at least SETUP_CYC cycles before each falling edge of mem_we_n. They do not change while mem_we_n is low, nor within HOLD_CYC cycles after it rises.
- R6: Between two strobes of one sequence, mem_we_n is high for at most WINDOW_CYC cycles. A byte held valid as soon as byte_ready rises gives a gap of HOLD_CYC+1+SETUP_CYC cycles.
- R7: The load window does not apply before the first strobe, so the first byte may arrive any number of cycles after the request without an underrun.
- R8: If, after the first strobe, no byte arrives in time to keep the window, byte_ready drops and the sequence ends early. Unsent bytes are not written. seq_underrun goes high and stays high until the next request is accepted.
- R9: After the final strobe of a complete sequence, mem_we_n stays high with mem_ce_n low for exactly HOLD_CYC+WINDOW_CYC cycles (at least WINDOW_CYC after an underrun). mem_ce_n then rises, and seq_done pulses for one cycle exactly PROG_CYC cycles later.
- R10: req_ready is low from the request's acceptance through the seq_done cycle. It is high again in the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Page-write request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_page | input | 9 | Page number, driven onto mem_addr[14:6] |
| req_len_m1 | input | 6 | Byte count minus one (0 means 1, 63 means 64) |
| byte_valid | input | 1 | Byte offered |
| byte_ready | output | 1 | Byte can be taken now |
| byte_off | input | 6 | Offset of the byte inside the page |
| byte_data | input | 8 | Byte value |
| mem_ce_n | output | 1 | Device chip-enable, active low |
| mem_we_n | output | 1 | Device write strobe, active low |
| mem_oe_n | output | 1 | Device output-enable, held high |
| mem_addr | output | 15 | Device address |
| mem_dq | output | 8 | Write data toward the device |
| mem_dq_oe | output | 1 | High while the sequencer drives mem_dq |
| seq_done | output | 1 | One-cycle pulse at the end of the write-cycle time |
| seq_underrun | output | 1 | Sequence ended early because the stream stalled |

## Verification
The hardest case to reach from the ports is a byte that arrives in the very last cycle where byte_ready still allows it. That byte must give a gap of exactly WINDOW_CYC, and the next cycle must instead end the sequence. The bench gets there by holding byte_valid low for a counted number of cycles while byte_ready is high. One scenario delays each byte to exactly the limit and expects the widest legal gap and no flag. Another stops the stream after two of four bytes and expects the early end, the flag and a normal done pulse. A follow-up request checks that the flag clears.

// File: rtl/pgwr_pkg.sv
`timescale 1ns/1ps
package pgwr_pkg;

  typedef enum logic [2:0] {
    P_IDLE,
    P_LOAD,
    P_SETUP,
    P_STROBE,
    P_HOLD,
    P_TAIL,
    P_PROG
  } phase_t;

  function automatic int unsigned max_of(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // The strobe gap, if a byte is taken now: cycles already high, plus this
  // cycle, plus the setup cycles before the next falling edge.
  function automatic logic gap_allows(int unsigned high_sofar,
                                      int unsigned setup_c,
                                      int unsigned win_c);
    return (high_sofar + 1 + setup_c) <= win_c;
  endfunction

  function automatic logic drives_bus(phase_t p);
    return (p == P_SETUP) || (p == P_STROBE) || (p == P_HOLD);
  endfunction

  function automatic logic in_window(phase_t p);
    return (p == P_HOLD) || (p == P_LOAD) || (p == P_SETUP) || (p == P_TAIL);
  endfunction

  function automatic logic chip_on(phase_t p);
    return (p != P_IDLE) && (p != P_PROG);
  endfunction

endpackage

// File: rtl/pgwr_timer.sv
`timescale 1ns/1ps
module pgwr_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pgwr_gapmon.sv
`timescale 1ns/1ps
module pgwr_gapmon
  import pgwr_pkg::*;
#(
  parameter int CW         = 5,
  parameter int SETUP_CYC  = 2,
  parameter int WINDOW_CYC = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_t        phase,
  output logic [CW-1:0] high_cnt,
  output logic          load_ok
);
  localparam logic [CW-1:0] SAT = {CW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                high_cnt <= '0;
    else if (phase == P_STROBE)                high_cnt <= '0;
    else if (in_window(phase) && high_cnt != SAT) high_cnt <= high_cnt + 1'b1;
  end

  assign load_ok = gap_allows(int'(high_cnt), SETUP_CYC, WINDOW_CYC);
endmodule

// File: rtl/pgwr_ctrl.sv
`timescale 1ns/1ps
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int OFF_W      = 6,
  parameter int TW         = 6,
  parameter int CW         = 5,
  parameter int SETUP_CYC  = 2,
  parameter int PULSE_CYC  = 3,
  parameter int HOLD_CYC   = 2,
  parameter int WINDOW_CYC = 12,
  parameter int PROG_CYC   = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [OFF_W-1:0] req_len_m1,
  input  logic             byte_valid,
  input  logic             tmr_zero,
  input  logic             load_ok,
  input  logic [CW-1:0]    high_cnt,
  output phase_t           phase,
  output logic             tmr_load,
  output logic [TW-1:0]    tmr_val,
  output logic             req_ready,
  output logic             byte_ready,
  output logic             req_take,
  output logic             byte_take,
  output logic             underrun,
  output logic             done
);
  phase_t           phase_q, phase_d;
  logic [OFF_W-1:0] rem_q;
  logic             first_q, err_q, done_q;
  logic             stall_out;

  assign req_ready  = (phase_q == P_IDLE) && !done_q;
  assign byte_ready = (phase_q == P_LOAD) && (first_q || load_ok);
  assign req_take   = req_valid && req_ready;
  assign byte_take  = byte_valid && byte_ready;
  assign stall_out  = (phase_q == P_LOAD) && !first_q && !load_ok;

  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (phase_q)
      P_IDLE:   if (req_take) phase_d = P_LOAD;
      P_LOAD: begin
        if (byte_take) begin
          phase_d = P_SETUP; tmr_load = 1'b1; tmr_val = TW'(SETUP_CYC - 1);
        end else if (stall_out) begin
          phase_d = P_TAIL;  tmr_load = 1'b1; tmr_val = TW'(WINDOW_CYC - 1);
        end
      end
      P_SETUP:  if (tmr_zero) begin
        phase_d = P_STROBE; tmr_load = 1'b1; tmr_val = TW'(PULSE_CYC - 1);
      end
      P_STROBE: if (tmr_zero) begin
        phase_d = P_HOLD; tmr_load = 1'b1; tmr_val = TW'(HOLD_CYC - 1);
      end
      P_HOLD:   if (tmr_zero) begin
        if (rem_q == '0) begin
          phase_d = P_TAIL; tmr_load = 1'b1; tmr_val = TW'(WINDOW_CYC - 1);
        end else begin
          phase_d = P_LOAD;
        end
      end
      P_TAIL:   if (tmr_zero) begin
        phase_d = P_PROG; tmr_load = 1'b1; tmr_val = TW'(PROG_CYC - 1);
      end
      P_PROG:   if (tmr_zero) phase_d = P_IDLE;
      default:  phase_d = P_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= P_IDLE;
      rem_q   <= '0;
      first_q <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= (phase_q == P_PROG) && tmr_zero;
      if (req_take) begin
        rem_q   <= req_len_m1;
        first_q <= 1'b1;
        err_q   <= 1'b0;
      end else begin
        if (phase_q == P_STROBE) first_q <= 1'b0;
        if (stall_out)           err_q   <= 1'b1;
        if (phase_q == P_HOLD && tmr_zero && rem_q != '0) rem_q <= rem_q - 1'b1;
      end
    end
  end

  assign phase    = phase_q;
  assign underrun = err_q;
  assign done     = done_q;

  // R6: the high gap closing at this falling edge fits the window
  a_r6_gap_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == P_SETUP && tmr_zero && !first_q) |-> (int'(high_cnt) + 1 <= WINDOW_CYC));

  // R8: the flag only rises when the stream left the load phase waiting
  a_r8_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> ($past(phase_q) == P_LOAD && phase_q == P_TAIL));
endmodule

// File: rtl/pgwr_bus.sv
`timescale 1ns/1ps
module pgwr_bus
  import pgwr_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int OFF_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_take,
  input  logic [PAGE_W-1:0]       req_page,
  input  logic                    byte_take,
  input  logic [OFF_W-1:0]        byte_off,
  input  logic [DATA_W-1:0]       byte_data,
  input  phase_t                  phase,
  output logic [PAGE_W+OFF_W-1:0] mem_addr,
  output logic [DATA_W-1:0]       mem_dq,
  output logic                    mem_dq_oe
);
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      off_q  <= '0;
      data_q <= '0;
    end else begin
      if (req_take)  page_q <= req_page;
      if (byte_take) begin
        off_q  <= byte_off;
        data_q <= byte_data;
      end
    end
  end

  assign mem_addr  = {page_q, off_q};
  assign mem_dq    = data_q;
  assign mem_dq_oe = drives_bus(phase);

  // R5: nothing moves on the bus while the strobe is low
  a_r5_stable_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_STROBE && $past(phase) == P_STROBE) |-> ($stable(mem_addr) && $stable(mem_dq)));
endmodule

// File: rtl/pgwr_seq.sv
`timescale 1ns/1ps
module pgwr_seq
  import pgwr_pkg::*;
#(
  parameter int PAGE_W     = 9,
  parameter int OFF_W      = 6,
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 2,
  parameter int PULSE_CYC  = 3,
  parameter int HOLD_CYC   = 2,
  parameter int WINDOW_CYC = 12,
  parameter int PROG_CYC   = 30
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [PAGE_W-1:0]       req_page,
  input  logic [OFF_W-1:0]        req_len_m1,
  input  logic                    byte_valid,
  output logic                    byte_ready,
  input  logic [OFF_W-1:0]        byte_off,
  input  logic [DATA_W-1:0]       byte_data,
  output logic                    mem_ce_n,
  output logic                    mem_we_n,
  output logic                    mem_oe_n,
  output logic [PAGE_W+OFF_W-1:0] mem_addr,
  output logic [DATA_W-1:0]       mem_dq,
  output logic                    mem_dq_oe,
  output logic                    seq_done,
  output logic                    seq_underrun
);
  localparam int MAXC = max_of(max_of(max_of(SETUP_CYC, PULSE_CYC),
                                      max_of(HOLD_CYC, WINDOW_CYC)), PROG_CYC);
  localparam int TW   = $clog2(MAXC + 1) + 1;
  localparam int CW   = $clog2(WINDOW_CYC + 2) + 1;
  localparam int AW   = PAGE_W + OFF_W;

  phase_t        phase;
  logic          tmr_load, tmr_zero, load_ok, req_take, byte_take;
  logic [TW-1:0] tmr_val;
  logic [CW-1:0] high_cnt;

  pgwr_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  pgwr_gapmon #(.CW(CW), .SETUP_CYC(SETUP_CYC), .WINDOW_CYC(WINDOW_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .phase(phase), .high_cnt(high_cnt), .load_ok(load_ok)
  );

  pgwr_ctrl #(
    .OFF_W(OFF_W), .TW(TW), .CW(CW), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC(HOLD_CYC), .WINDOW_CYC(WINDOW_CYC), .PROG_CYC(PROG_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len_m1(req_len_m1),
    .byte_valid(byte_valid), .tmr_zero(tmr_zero), .load_ok(load_ok), .high_cnt(high_cnt),
    .phase(phase), .tmr_load(tmr_load), .tmr_val(tmr_val), .req_ready(req_ready),
    .byte_ready(byte_ready), .req_take(req_take), .byte_take(byte_take),
    .underrun(seq_underrun), .done(seq_done)
  );

  pgwr_bus #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .req_take(req_take), .req_page(req_page),
    .byte_take(byte_take), .byte_off(byte_off), .byte_data(byte_data), .phase(phase),
    .mem_addr(mem_addr), .mem_dq(mem_dq), .mem_dq_oe(mem_dq_oe)
  );

  assign mem_ce_n = !chip_on(phase);
  assign mem_we_n = (phase != P_STROBE);
  assign mem_oe_n = 1'b1;

  // Strobe events brought out for the checks below
  logic          we_q;
  logic [TW-1:0] low_len;
  logic          strobe_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b1;
      low_len <= '0;
    end else begin
      we_q    <= mem_we_n;
      low_len <= mem_we_n ? '0 : low_len + 1'b1;
    end
  end
  assign strobe_rise = mem_we_n && !we_q;

  // R4: each strobe lasted exactly the pulse width
  a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_rise |-> (low_len == TW'(PULSE_CYC)));

  // R3: page bits stay put while the chip is selected
  a_r3_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr[AW-1:OFF_W]));

  // R10: no new request while busy
  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n || seq_done) |-> !req_ready);

  // R9: done is a single-cycle pulse, issued with the chip released
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> (mem_ce_n && mem_we_n) ##1 !seq_done);
endmodule

// File: tb/test_pgwr_seq.sv
`timescale 1ns/1ps
module test_pgwr_seq;
  localparam int SETUP = 2, PULSE = 3, HOLD = 2, WIN = 12, PROG = 30;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       req_valid = 1'b0, byte_valid = 1'b0;
  logic [8:0] req_page = '0;
  logic [5:0] req_len_m1 = '0, byte_off = '0;
  logic [7:0] byte_data = '0;
  logic       req_ready, byte_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic       seq_done, seq_underrun;
  logic [14:0] mem_addr;
  logic [7:0]  mem_dq;

  always #2.5 clk = ~clk;

  pgwr_seq #(.SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .HOLD_CYC(HOLD),
             .WINDOW_CYC(WIN), .PROG_CYC(PROG)) i_pgwr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_page(req_page), .req_len_m1(req_len_m1), .byte_valid(byte_valid),
    .byte_ready(byte_ready), .byte_off(byte_off), .byte_data(byte_data),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq(mem_dq), .mem_dq_oe(mem_dq_oe),
    .seq_done(seq_done), .seq_underrun(seq_underrun)
  );

  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- bus monitor (negedge samples) ----------------
  logic [8:0]  exp_page = '0;
  logic [22:0] prev_bus = '0;
  bit   prev_we = 1'b1, prev_ce = 1'b1, in_prog = 1'b0;
  int   lowc = 0, hic = 0, since_rise = 0, stab = 0, n_strobe = 0, max_gap = 0;
  int   width_bad = 0, setup_bad = 0, hold_bad = 0, page_bad = 0, rdy_bad = 0, oe_bad = 0;
  int   tail_len = 0, pc = 0, done_n = 0, done_at = 0;
  bit   done_rdy = 1'b0;
  int   wr_cnt [64];
  logic [7:0] img [64];

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n && req_ready) rdy_bad++;
      if (!mem_oe_n) oe_bad++;
      if (!mem_ce_n && mem_addr[14:6] != exp_page) page_bad++;
      if (!mem_ce_n && {mem_addr, mem_dq} != prev_bus) begin
        if (!mem_we_n) hold_bad++;
        else if (n_strobe > 0 && since_rise < HOLD) hold_bad++;
      end
      stab = ({mem_addr, mem_dq} == prev_bus) ? stab + 1 : 0;
      prev_bus = {mem_addr, mem_dq};
      if (!mem_we_n) begin
        if (prev_we) begin
          if (n_strobe > 0 && hic > max_gap) max_gap = hic;
          if (stab < SETUP) setup_bad++;
        end
        lowc++;
      end else begin
        if (!prev_we) begin
          if (lowc != PULSE) width_bad++;
          n_strobe++;
          wr_cnt[mem_addr[5:0]]++;
          img[mem_addr[5:0]] = mem_dq;
          lowc = 0; hic = 0; since_rise = 0;
        end
        if (!mem_ce_n) begin hic++; since_rise++; end
      end
      if (mem_ce_n && !prev_ce) begin tail_len = hic; pc = 0; in_prog = 1'b1; end
      else if (in_prog) pc++;
      if (seq_done) begin done_n++; done_at = pc; done_rdy = req_ready; in_prog = 1'b0; end
      prev_we = mem_we_n;
      prev_ce = mem_ce_n;
    end
  end

  // ---------------- stimulus ----------------
  logic [5:0] ofs_list [64];
  logic [7:0] dat_list [64];

  task automatic send_byte(input logic [5:0] o, input logic [7:0] d, input int k);
    int seen = 0;
    forever begin
      @(negedge clk);
      if (byte_ready) begin
        if (seen == k) begin
          byte_off = o; byte_data = d; byte_valid = 1'b1;
          @(posedge clk);
          @(negedge clk);
          byte_valid = 1'b0;
          return;
        end
        seen++;
      end
    end
  endtask

  // One page write: len bytes requested, 'supply' of them sent.
  task automatic run_seq(input string name, input logic [8:0] page, input int len,
                         input int supply, input int first_k, input int k);
    int exp_cnt [64];
    logic [7:0] exp_img [64];
    int mism = 0, waitc = 0;
    @(posedge clk);
    exp_page = page; n_strobe = 0; max_gap = 0; width_bad = 0; setup_bad = 0;
    hold_bad = 0; page_bad = 0; rdy_bad = 0; oe_bad = 0; done_n = 0; tail_len = 0;
    for (int i = 0; i < 64; i++) begin wr_cnt[i] = 0; exp_cnt[i] = 0; exp_img[i] = '0; end
    @(negedge clk);
    req_page = page; req_len_m1 = 6'(len - 1); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(seq_underrun == 1'b0, "R8", {name, " flag cleared on accept"}, seq_underrun, 0);
    for (int i = 0; i < supply; i++) begin
      send_byte(ofs_list[i], dat_list[i], (i == 0) ? first_k : k);
      exp_cnt[ofs_list[i]]++;
      exp_img[ofs_list[i]] = dat_list[i];
    end
    while (!seq_done && waitc < 5000) begin @(negedge clk); waitc++; end
    @(posedge clk);
    for (int i = 0; i < 64; i++)
      if (wr_cnt[i] != exp_cnt[i] || (exp_cnt[i] != 0 && img[i] != exp_img[i])) mism++;
    chk(done_n == 1, "R9", {name, " done pulses"}, done_n, 1);
    chk(n_strobe == supply, "R2", {name, " strobe count"}, n_strobe, supply);
    chk(mism == 0, "R2", {name, " page image mismatches"}, mism, 0);
    chk(page_bad == 0 && oe_bad == 0, "R3", {name, " page/oe violations"}, page_bad + oe_bad, 0);
    chk(width_bad == 0, "R4", {name, " strobe width errors"}, width_bad, 0);
    chk(setup_bad + hold_bad == 0, "R5", {name, " setup/hold errors"}, setup_bad + hold_bad, 0);
    if (supply > 1)
      chk(max_gap == k + HOLD + 1 + SETUP && max_gap <= WIN, "R6", {name, " widest gap"},
          max_gap, k + HOLD + 1 + SETUP);
    if (supply == len) begin
      chk(tail_len == HOLD + WIN, "R9", {name, " tail length"}, tail_len, HOLD + WIN);
      chk(seq_underrun == 1'b0, "R8", {name, " no underrun"}, seq_underrun, 0);
    end else begin
      chk(tail_len >= WIN, "R9", {name, " tail after underrun"}, tail_len, WIN);
      chk(seq_underrun == 1'b1, "R8", {name, " underrun flagged"}, seq_underrun, 1);
    end
    chk(done_at == PROG, "R9", {name, " done delay after ce release"}, done_at, PROG);
    chk(rdy_bad == 0 && done_rdy == 1'b0, "R10", {name, " ready while busy"}, rdy_bad + done_rdy, 0);
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", {name, " ready after done"}, req_ready, 1);
    if (supply != len)
      chk(seq_underrun == 1'b1, "R8", {name, " flag persists"}, seq_underrun, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1", "strobes idle", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
    chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    chk(byte_ready == 1'b0, "R1", "byte_ready", byte_ready, 0);
    chk(!seq_done && !seq_underrun, "R1", "done/underrun", {seq_done, seq_underrun}, 0);
  endtask

  task automatic t_full_scrambled();  // R2: all 64 offsets, out of order
    for (int i = 0; i < 64; i++) begin
      ofs_list[i] = 6'((i * 37 + 5) % 64); dat_list[i] = 8'(i ^ 8'hA5);
    end
    run_seq("full64", 9'h15A, 64, 64, 0, 0);
  endtask

  task automatic t_single();
    ofs_list[0] = 6'd63; dat_list[0] = 8'h3C;
    run_seq("single", 9'h1FF, 1, 1, 0, 0);
  endtask

  task automatic t_slow_edge();  // R6: each byte at the last legal cycle
    for (int i = 0; i < 5; i++) begin ofs_list[i] = 6'(40 - 3 * i); dat_list[i] = 8'(8'h11 * i); end
    run_seq("window_edge", 9'h003, 5, 5, 0, WIN - 1 - SETUP - HOLD);
  endtask

  task automatic t_first_late();  // R7: long wait before the first byte
    for (int i = 0; i < 3; i++) begin ofs_list[i] = 6'(i * 20); dat_list[i] = 8'(8'hC0 + i); end
    run_seq("first_late", 9'h0AA, 3, 3, 30, 0);
  endtask

  task automatic t_underrun();  // R8: stream stops after two of four bytes
    for (int i = 0; i < 4; i++) begin ofs_list[i] = 6'(10 + i); dat_list[i] = 8'(8'h70 + i); end
    run_seq("underrun", 9'h101, 4, 2, 0, 0);
  endtask

  task automatic t_after_underrun();
    ofs_list[0] = 6'd7; dat_list[0] = 8'h99;
    ofs_list[1] = 6'd2; dat_list[1] = 8'h55;
    run_seq("recover", 9'h0F0, 2, 2, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin wr_cnt[i] = 0; img[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full_scrambled();
    t_single();
    t_slow_edge();
    t_first_late();
    t_underrun();
    t_after_underrun();
    t_reset();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule